// File: doc/BRIEF.md
# Dual-CPU Bus-Sharing Arbiter

This block sits between the bus of a master CPU and the bus of a second, slave computer. The master spends most of its time drawing a video display. It tells the hardware when it does so by writing to two I/O ports: one turns its NMI generator on and the other turns it off. The block decodes those writes into a one-bit machine state. That state is either "video" or "free".

While the master is free to run its control program, the block requests the slave's bus. Once the slave acknowledges, the block opens the address path toward the slave. It also opens the data path for master memory reads in the upper half of the address space, and in that case it disables the master's own RAM chip select. The slave's 16K RAM echoes into the upper half of memory, so the master can copy the slave's screen file with one block move. The slave CPU only runs while the master is drawing video. Tri-state buffers are modelled as active-low enable outputs. The address the slave sees is presented folded onto its RAM image.

Top module: `bus_share_arbiter`

## Requirements
- R1: After a synchronous reset the machine state is "video", so `slv_busrq_n` reads 1 from the first edge with `rst` high.
- R2: A qualified I/O write (`mst_iorq_n`=0 and `mst_wr_n`=0) with address bit 1 low and address bit 0 high puts the block in the "free" state. `slv_busrq_n` reads 0 after that clock edge.
- R3: A qualified I/O write with address bit 0 low puts the block in the "video" state, and `slv_busrq_n` reads 1 after the edge. If both bits 0 and 1 are low, "video" wins.
- R4: A cycle that is not a qualified I/O write leaves the machine state unchanged. This covers I/O reads, memory cycles, and writes with both bits 0 and 1 high.
- R5: `addr_buf_oe_n` is 0 exactly when `slv_busrq_n` is 0 and `slv_busack_n` is 0. The output is combinational in the current inputs.
- R6: `data_buf_oe_n` is 0 exactly when `mst_rd_n`=0, `mst_mreq_n`=0, address bit 15 is 1 and `slv_busrq_n`=0.
- R7: `mst_ramcs_n` is forced to 1 while `data_buf_oe_n` is 0. Otherwise it follows `mst_ramcs_n_in`.
- R8: While `addr_buf_oe_n` is 0, `slv_addr` equals the master address with bit 15 cleared (master 0xC000 reaches slave 0x4000). Otherwise `slv_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master bus clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_addr | input | 16 | Master address bus |
| mst_iorq_n | input | 1 | Master I/O request, active low |
| mst_mreq_n | input | 1 | Master memory request, active low |
| mst_rd_n | input | 1 | Master read strobe, active low |
| mst_wr_n | input | 1 | Master write strobe, active low |
| mst_ramcs_n_in | input | 1 | Master internal RAM select from its own decoder, active low |
| slv_busack_n | input | 1 | Slave bus acknowledge, active low |
| slv_busrq_n | output | 1 | Bus request to the slave, active low |
| addr_buf_oe_n | output | 1 | Address buffer enable toward slave, active low |
| data_buf_oe_n | output | 1 | Slave-to-master data buffer enable, active low |
| mst_ramcs_n | output | 1 | Gated master internal RAM select, active low |
| slv_addr | output | 16 | Address presented to the slave RAM |

## Verification
State decoding and read steering can fall in the same cycle. An I/O write that flips the machine state can coincide with an upper-memory read strobe. The bench provokes this by sweeping every combination of the control strobes and the address bits 0, 1 and 15 together, in both states. It then judges two things. The combinational enables must follow the state held before the edge. The new state must appear on `slv_busrq_n` only after the edge.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        MS_VIDEO = 1'b0,
        MS_FREE  = 1'b1
    } mstate_e;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'd0,
        CMD_NMI_ON  = 2'd1,
        CMD_NMI_OFF = 2'd2
    } cmd_e;

    // Active-high view of the master's strobes.
    typedef struct packed {
        logic iorq;
        logic mreq;
        logic rd;
        logic wr;
    } ctl_s;

    function automatic ctl_s to_ctl(input logic iorq_n, input logic mreq_n,
                                    input logic rd_n, input logic wr_n);
        ctl_s c;
        c.iorq = ~iorq_n;
        c.mreq = ~mreq_n;
        c.rd   = ~rd_n;
        c.wr   = ~wr_n;
        return c;
    endfunction

    // NMI-on (video) has priority over NMI-off when both port bits are low.
    function automatic cmd_e decode_cmd(input ctl_s c, input logic on_bit, input logic off_bit);
        cmd_e r;
        r = CMD_NONE;
        if (c.iorq && c.wr) begin
            if (!on_bit)       r = CMD_NMI_ON;
            else if (!off_bit) r = CMD_NMI_OFF;
        end
        return r;
    endfunction

endpackage

// File: rtl/bsa_state_dec.sv
module bsa_state_dec
    import bsa_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ON_BIT  = 0,
    parameter int OFF_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_s              ctl,
    input  logic [ADDR_W-1:0] addr,
    output mstate_e           state
);
    cmd_e cmd;

    always_comb cmd = decode_cmd(ctl, addr[ON_BIT], addr[OFF_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_VIDEO;
        end else begin
            case (cmd)
                CMD_NMI_ON:  state <= MS_VIDEO;
                CMD_NMI_OFF: state <= MS_FREE;
                default:     state <= state;
            endcase
        end
    end
endmodule

// File: rtl/bsa_bus_gate.sv
module bsa_bus_gate
    import bsa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  mstate_e           state,
    input  logic              busack_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              busrq_n,
    output logic              addr_oe_n,
    output logic [ADDR_W-1:0] slv_addr
);
    localparam int HI = ADDR_W - 1;

    logic granted;

    always_comb begin
        busrq_n   = (state == MS_FREE) ? 1'b0 : 1'b1;
        granted   = !busrq_n && !busack_n;
        addr_oe_n = !granted;
    end

    // The slave ignores the top bit, so the upper half echoes its RAM.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
        if (i == HI) begin : g_fold
            assign slv_addr[i] = 1'b0;
        end else begin : g_pass
            assign slv_addr[i] = granted & addr[i];
        end
    end
endmodule

// File: rtl/bsa_read_steer.sv
module bsa_read_steer
    import bsa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  ctl_s              ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busrq_n,
    input  logic              ramcs_n_in,
    output logic              data_oe_n,
    output logic              ramcs_n
);
    localparam int HI = ADDR_W - 1;

    logic hi_read;

    always_comb begin
        hi_read   = ctl.rd && ctl.mreq && addr[HI] && !busrq_n;
        data_oe_n = !hi_read;
        ramcs_n   = hi_read ? 1'b1 : ramcs_n_in;
    end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
    import bsa_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ON_BIT  = 0,
    parameter int OFF_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mst_addr,
    input  logic              mst_iorq_n,
    input  logic              mst_mreq_n,
    input  logic              mst_rd_n,
    input  logic              mst_wr_n,
    input  logic              mst_ramcs_n_in,
    input  logic              slv_busack_n,
    output logic              slv_busrq_n,
    output logic              addr_buf_oe_n,
    output logic              data_buf_oe_n,
    output logic              mst_ramcs_n,
    output logic [ADDR_W-1:0] slv_addr
);
    ctl_s    ctl;
    mstate_e state;

    always_comb ctl = to_ctl(mst_iorq_n, mst_mreq_n, mst_rd_n, mst_wr_n);

    bsa_state_dec #(.ADDR_W(ADDR_W), .ON_BIT(ON_BIT), .OFF_BIT(OFF_BIT)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .addr  (mst_addr),
        .state (state)
    );

    bsa_bus_gate #(.ADDR_W(ADDR_W)) u_gate (
        .state     (state),
        .busack_n  (slv_busack_n),
        .addr      (mst_addr),
        .busrq_n   (slv_busrq_n),
        .addr_oe_n (addr_buf_oe_n),
        .slv_addr  (slv_addr)
    );

    bsa_read_steer #(.ADDR_W(ADDR_W)) u_steer (
        .ctl        (ctl),
        .addr       (mst_addr),
        .busrq_n    (slv_busrq_n),
        .ramcs_n_in (mst_ramcs_n_in),
        .data_oe_n  (data_buf_oe_n),
        .ramcs_n    (mst_ramcs_n)
    );
endmodule

// File: rtl/bus_share_arbiter_chk.sv
module bus_share_arbiter_chk #(
    parameter int ADDR_W  = 16,
    parameter int ON_BIT  = 0,
    parameter int OFF_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mst_addr,
    input logic              mst_iorq_n,
    input logic              mst_mreq_n,
    input logic              mst_rd_n,
    input logic              mst_wr_n,
    input logic              mst_ramcs_n_in,
    input logic              slv_busack_n,
    input logic              slv_busrq_n,
    input logic              addr_buf_oe_n,
    input logic              data_buf_oe_n,
    input logic              mst_ramcs_n,
    input logic [ADDR_W-1:0] slv_addr
);
    localparam int HI = ADDR_W - 1;

    logic io_wr;
    assign io_wr = !mst_iorq_n && !mst_wr_n;

    p_reset_video_r1: assert property (@(posedge clk) rst |=> slv_busrq_n);

    p_free_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && mst_addr[ON_BIT] && !mst_addr[OFF_BIT]) |=> !slv_busrq_n);

    p_video_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !mst_addr[ON_BIT]) |=> slv_busrq_n);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && !(mst_addr[ON_BIT] && mst_addr[OFF_BIT])) |=> $stable(slv_busrq_n));

    p_addr_oe_r5: assert property (@(posedge clk) disable iff (rst)
        !addr_buf_oe_n |-> (!slv_busrq_n && !slv_busack_n));

    p_data_oe_r6: assert property (@(posedge clk) disable iff (rst)
        !data_buf_oe_n |-> (!mst_rd_n && !mst_mreq_n && mst_addr[HI] && !slv_busrq_n));

    p_ramcs_r7: assert property (@(posedge clk) disable iff (rst)
        !data_buf_oe_n |-> mst_ramcs_n);

    p_echo_r8: assert property (@(posedge clk) disable iff (rst)
        !addr_buf_oe_n |-> (slv_addr[HI] == 1'b0 && slv_addr[HI-1:0] == mst_addr[HI-1:0]));
endmodule

bind bus_share_arbiter bus_share_arbiter_chk #(
    .ADDR_W(ADDR_W), .ON_BIT(ON_BIT), .OFF_BIT(OFF_BIT)
) u_chk (.*);

// File: tb/bus_share_arbiter_bench.sv
module bus_share_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mst_addr = 16'hFFFF;
    logic        mst_iorq_n = 1'b1, mst_mreq_n = 1'b1, mst_rd_n = 1'b1, mst_wr_n = 1'b1;
    logic        mst_ramcs_n_in = 1'b1, slv_busack_n = 1'b1;
    logic        slv_busrq_n, addr_buf_oe_n, data_buf_oe_n, mst_ramcs_n;
    logic [15:0] slv_addr;

    int checks = 0;
    int errors = 0;
    bit exp_free = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_share_arbiter u_bus_share_arbiter (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        mst_iorq_n = 1'b1; mst_mreq_n = 1'b1; mst_rd_n = 1'b1; mst_wr_n = 1'b1;
        mst_addr = 16'hFFFF;
    endtask

    // Issue one I/O write to move to the requested state.
    task automatic set_state(input bit free);
        @(negedge clk);
        mst_iorq_n = 1'b0; mst_wr_n = 1'b0;
        mst_addr = free ? 16'hFFFD : 16'hFFFE;
        @(posedge clk); #1;
        exp_free = free;
        chk(free ? "R2" : "R3", {15'd0, slv_busrq_n}, {15'd0, !free});
        @(negedge clk); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {15'd0, slv_busrq_n}, 16'd1);
        @(negedge clk); rst = 1'b0;

        // Echo point: master 0xC000 reaches slave 0x4000.
        set_state(1'b1);
        @(negedge clk);
        slv_busack_n = 1'b0; mst_mreq_n = 1'b0; mst_rd_n = 1'b0; mst_addr = 16'hC000;
        #1;
        chk("R8", slv_addr, 16'h4000);
        chk("R6", {15'd0, data_buf_oe_n}, 16'd0);
        @(negedge clk); idle(); slv_busack_n = 1'b1;

        // Reset while free returns to video.
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", {15'd0, slv_busrq_n}, 16'd1);
        @(negedge clk); rst = 1'b0; exp_free = 1'b0;

        for (int st = 0; st < 2; st++) begin
            for (int v = 0; v < 512; v++) begin
                bit brq, aoe, doe, nxt;
                logic [15:0] a;
                set_state(st[0]);
                @(negedge clk);
                a = {v[5], 15'(v * 1237)} ;
                a[0] = v[6]; a[1] = v[7];
                mst_iorq_n = v[0]; mst_wr_n = v[1]; mst_rd_n = v[2]; mst_mreq_n = v[3];
                slv_busack_n = v[4]; mst_addr = a; mst_ramcs_n_in = v[8];
                #1;
                brq = exp_free;
                aoe = brq && !v[4];
                doe = !v[2] && !v[3] && v[5] && brq;
                chk("R5", {15'd0, addr_buf_oe_n}, {15'd0, !aoe});
                chk("R6", {15'd0, data_buf_oe_n}, {15'd0, !doe});
                chk("R7", {15'd0, mst_ramcs_n}, {15'd0, doe ? 1'b1 : v[8]});
                chk("R8", slv_addr, aoe ? {1'b0, a[14:0]} : 16'h0000);
                // State before the edge still drives the request.
                chk("R4", {15'd0, slv_busrq_n}, {15'd0, !brq});
                nxt = exp_free;
                if (!v[0] && !v[1]) begin
                    if (!v[6])      nxt = 1'b0;
                    else if (!v[7]) nxt = 1'b1;
                end
                @(posedge clk); #1;
                exp_free = nxt;
                if (!v[0] && !v[1] && !v[6])
                    chk("R3", {15'd0, slv_busrq_n}, {15'd0, !nxt});
                else if (!v[0] && !v[1] && !v[7])
                    chk("R2", {15'd0, slv_busrq_n}, {15'd0, !nxt});
                else
                    chk("R4", {15'd0, slv_busrq_n}, {15'd0, !nxt});
                @(negedge clk); idle(); slv_busack_n = 1'b1; mst_ramcs_n_in = 1'b1;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule